// File: doc/BRIEF.md
# Single-Stage Logarithmic Integer Square Root

This unit returns an approximate integer square root of a 16-bit unsigned operand in one registered cycle. It never forms a logarithm or an antilogarithm as an explicit value. A leading-one detector yields the characteristic k. A normalising shifter left-aligns the bits below the leading one to form a 15-bit fraction m, so the operand is 2^k·(1+m).

The least significant bit of k picks one of two families of piecewise-linear correction segments. Each family is a chord fit of sqrt((1+m)·2^(k mod 2)) over equal slices of m, and each chord is raised by half of its worst sag so that the error is centred. A constant one is placed above the 16-bit corrected fraction. A final left shift by floor(k/2) scales the result, and the integer part is kept.

A strobe on the input captures a result one cycle later, together with an output valid flag. A zero operand bypasses the leading-one path.

Top module: `sqrt_approx_unit`

## Requirements
- R1: While rst_ni is low, valid_o and root_o are 0, whatever valid_i and data_i do.
- R2: valid_o is 1 in exactly the cycle that follows a clock edge at which valid_i was 1, and is 0 otherwise.
- R3: root_o changes only at an edge where valid_i is 1. With valid_i low it holds its value while data_i changes.
- R4: An operand of 0 gives root_o = 0.
- R5: An operand 4^j (j = 0..7) gives exactly 2^j. For example, 1 gives 1 and 16384 gives 128.
- R6: For every operand N, root_o is within one of floor(sqrt(N)).
- R7: root_o never exceeds sqrt(N)·1.0034. In integer form, root_o²·1000000 ≤ N·1006812.
- R8: A corrected fraction above its 16-bit range saturates instead of wrapping. Operand 65535 gives 255.
- R9: An operand 2^(2j+1) (odd characteristic, m = 0) gives floor(2^j·√2). For j = 0..7 this is 1, 2, 5, 11, 22, 45, 90, 181.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| data_i | input | 16 | Unsigned operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| root_o | output | 8 | Approximate integer square root |

## Verification
A wrong characteristic or normalisation shift shows up at once as a result off by roughly a factor of √2 or 2 at the next valid cycle. The powers of four and two catch this, as does the full sweep. A corrupted segment base or slope leaves only a narrow band of operands outside the ±1 window or over the 0.34% ceiling. For that reason every operand is swept. A missing saturation shows up only at the very top of the range, where 65535 wraps to about 128. Pipeline faults show up within one cycle as a valid flag or a held root that does not follow the strobe.

// File: rtl/sqrt_approx_pkg.sv
package sqrt_approx_pkg;
  // bitwise integer square root, used for segment constants and checks
  function automatic longint unsigned isqrt_u64(input longint unsigned v);
    longint unsigned res;
    longint unsigned cand;
    res = 0;
    for (int i = 31; i >= 0; i--) begin
      cand = res | (64'd1 << i);
      if (cand * cand <= v) res = cand;
    end
    return res;
  endfunction
endpackage

// File: rtl/sqrt_lead_norm.sv
module sqrt_lead_norm #(
  parameter int IN_W = 16,
  localparam int K_W = $clog2(IN_W),
  localparam int M_W = IN_W - 1
) (
  input  logic [IN_W-1:0] data_i,
  output logic [K_W-1:0]  char_o,
  output logic [M_W-1:0]  frac_o
);
  logic [IN_W-1:0] norm;

  always_comb begin
    char_o = '0;
    for (int i = 0; i < IN_W; i++)
      if (data_i[i]) char_o = K_W'(i);
  end

  assign norm   = data_i << (K_W'(M_W) - char_o);
  assign frac_o = norm[M_W-1:0];

  // normalised word must carry the leading one at its top (R6)
  always_comb begin
    if (data_i != '0)
      assert_norm_lead_R6: assert (norm[IN_W-1] == 1'b1);
  end
endmodule

// File: rtl/sqrt_seg_corr.sv
module sqrt_seg_corr #(
  parameter int M_W    = 15,
  parameter int FRAC_W = 16,
  parameter int RGN_W  = 2,
  localparam int RGNS  = 1 << RGN_W,
  localparam int LOC_W = M_W - RGN_W,
  localparam int Y_W   = FRAC_W + 2
) (
  input  logic              odd_i,
  input  logic [M_W-1:0]    frac_i,
  output logic [FRAC_W-1:0] corr_o
);
  localparam logic [Y_W-1:0] ONE_Y = Y_W'(1) << FRAC_W;
  localparam logic [Y_W-1:0] TOP_Y = Y_W'(1) << (FRAC_W + 1);

  logic [Y_W-1:0]    base_tbl  [2][RGNS];
  logic [FRAC_W-1:0] slope_tbl [2][RGNS];

  for (genvar f = 0; f < 2; f++) begin : g_fam
    for (genvar r = 0; r < RGNS; r++) begin : g_rgn
      localparam int SH = 2 * FRAC_W + f - RGN_W;
      localparam longint unsigned Y0 =
        sqrt_approx_pkg::isqrt_u64(64'(RGNS + r) << SH);
      localparam longint unsigned Y1 =
        sqrt_approx_pkg::isqrt_u64(64'(RGNS + r + 1) << SH);
      localparam longint unsigned YM =
        sqrt_approx_pkg::isqrt_u64(64'(2 * RGNS + 2 * r + 1) << (SH - 1));
      localparam longint unsigned SAG = YM - (Y0 + Y1) / 2;
      assign base_tbl[f][r]  = Y_W'(Y0 + SAG / 2);
      assign slope_tbl[f][r] = FRAC_W'(Y1 - Y0);
    end
  end

  logic [RGN_W-1:0]        rgn;
  logic [LOC_W-1:0]        loc;
  logic [Y_W-1:0]          base_sel;
  logic [FRAC_W-1:0]       slope_sel;
  logic [FRAC_W+LOC_W-1:0] prod;
  logic [Y_W-1:0]          y_sum;

  assign rgn       = frac_i[M_W-1 -: RGN_W];
  assign loc       = frac_i[LOC_W-1:0];
  assign base_sel  = base_tbl[odd_i][rgn];
  assign slope_sel = slope_tbl[odd_i][rgn];
  assign prod      = (FRAC_W+LOC_W)'(slope_sel) * (FRAC_W+LOC_W)'(loc);
  assign y_sum     = base_sel + Y_W'(prod[FRAC_W+LOC_W-1:LOC_W]);

  // saturate rather than wrap past 2.0 (R8)
  assign corr_o = (y_sum >= TOP_Y) ? '1 : FRAC_W'(y_sum - ONE_Y);

  always_comb begin
    assert_base_window_R6: assert (base_sel >= ONE_Y && base_sel < TOP_Y + (ONE_Y >> 6));
  end
endmodule

// File: rtl/sqrt_scale.sv
module sqrt_scale #(
  parameter int FRAC_W = 16,
  parameter int SH_W   = 3,
  parameter int OUT_W  = 8,
  localparam int WIDE_W = FRAC_W + 1 + OUT_W
) (
  input  logic [FRAC_W-1:0] corr_i,
  input  logic [SH_W-1:0]   shift_i,
  output logic [OUT_W-1:0]  root_o
);
  logic [WIDE_W-1:0] wide;

  assign wide   = WIDE_W'({1'b1, corr_i}) << shift_i;
  assign root_o = wide[FRAC_W +: OUT_W];
endmodule

// File: rtl/sqrt_approx_unit.sv
module sqrt_approx_unit #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 16,
  parameter int RGN_W  = 2,
  localparam int K_W   = $clog2(IN_W),
  localparam int M_W   = IN_W - 1,
  localparam int OUT_W = IN_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] root_o
);
  logic [K_W-1:0]    chr;
  logic [M_W-1:0]    frac;
  logic [FRAC_W-1:0] corr;
  logic [OUT_W-1:0]  scaled;
  logic [OUT_W-1:0]  root_next;

  sqrt_lead_norm #(.IN_W(IN_W)) u_lead (
    .data_i (data_i),
    .char_o (chr),
    .frac_o (frac)
  );

  sqrt_seg_corr #(.M_W(M_W), .FRAC_W(FRAC_W), .RGN_W(RGN_W)) u_corr (
    .odd_i  (chr[0]),
    .frac_i (frac),
    .corr_o (corr)
  );

  sqrt_scale #(.FRAC_W(FRAC_W), .SH_W(K_W-1), .OUT_W(OUT_W)) u_scale (
    .corr_i  (corr),
    .shift_i (chr[K_W-1:1]),
    .root_o  (scaled)
  );

  assign root_next = (data_i == '0) ? '0 : scaled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      root_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) root_o <= root_next;
    end
  end

  assert_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(root_o));
  assert_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i == '0) |=> root_o == '0);
  assert_unit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i == IN_W'(1)) |=> root_o == OUT_W'(1));
  assert_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (64'(root_next) + 64'd2) * (64'(root_next) + 64'd2) > 64'(data_i));
  assert_ceiling_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> 64'(root_next) * 64'(root_next) * 64'd1000000 <= 64'(data_i) * 64'd1006812);
endmodule

// File: tb/sim_sqrt_approx_unit.sv
module sim_sqrt_approx_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        valid_o;
  logic [7:0]  root_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic        prev_v = 1'b0;
  logic [15:0] prev_d = '0;
  logic [7:0]  held = '0;

  sqrt_approx_unit u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i),
    .data_i (data_i), .valid_o (valid_o), .root_o (root_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int ref_isqrt(input int n);
    int r = 0;
    for (int b = 15; b >= 0; b--)
      if ((r | (1 << b)) * (r | (1 << b)) <= n) r = r | (1 << b);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_value(input int n);
    int r = int'(root_o);
    int f = ref_isqrt(n);
    longint lhs = longint'(r) * r * 1000000;
    longint rhs = longint'(n) * 1006812;
    chk(r + 1 >= f && r <= f + 1, "R6 within one of floor root", r, f);
    chk(lhs <= rhs, "R7 relative ceiling", r, f);
    if (n == 0) chk(r == 0, "R4 zero operand", r, 0);
    if (n == 65535) chk(r == 255, "R8 saturation at top", r, 255);
    for (int j = 0; j < 8; j++) begin
      if (n == (1 << (2*j))) chk(r == (1 << j), "R5 power of four", r, 1 << j);
      if (n == (1 << (2*j+1))) chk(r == ref_isqrt(n), "R9 odd characteristic", r, ref_isqrt(n));
    end
  endtask

  task automatic step(input logic v, input logic [15:0] d);
    @(negedge clk_i);
    if (prev_v) begin
      chk(valid_o == 1'b1, "R2 valid after strobe", int'(valid_o), 1);
      check_value(int'(prev_d));
      held = root_o;
    end else begin
      chk(valid_o == 1'b0, "R2 valid low when idle", int'(valid_o), 0);
      chk(root_o == held, "R3 root held while idle", int'(root_o), int'(held));
    end
    valid_i = v;
    data_i  = d;
    prev_v  = v;
    prev_d  = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    // reset with activity on the inputs (R1)
    valid_i = 1'b1;
    data_i  = 16'h1234;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
      chk(root_o == 8'd0, "R1 root in reset", int'(root_o), 0);
    end
    valid_i = 1'b0;
    rst_ni  = 1'b1;

    // directed corners
    step(1'b1, 16'd0);
    step(1'b1, 16'd1);
    step(1'b0, 16'd9999);
    step(1'b0, 16'd4);
    step(1'b1, 16'd65535);
    for (int j = 0; j < 8; j++) step(1'b1, 16'(1 << (2*j)));
    for (int j = 0; j < 8; j++) step(1'b1, 16'(1 << (2*j+1)));
    step(1'b1, 16'd65534);
    step(1'b0, 16'd0);

    // exhaustive back-to-back sweep
    for (int n = 0; n < 65536; n++) step(1'b1, 16'(n));

    // random with idle gaps
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d = 16'($urandom);
      if (($urandom % 8) == 0) d = 16'($urandom % 4);
      step(($urandom % 3) != 0, d);
    end
    step(1'b0, 16'd0);
    step(1'b0, 16'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule